// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single byte from the host to a PS/2 device over the two open-drain bus wires. The device generates the bus clock, so the host cannot simply shift data out. It first inhibits the bus by pulling the clock wire low for a fixed hold time. It then pulls the data wire low, which places the start bit, and lets go of the clock. After that it presents one bit after each qualified falling clock edge that the device produces. The eight data bits go out least significant first, followed by an odd parity bit. The data wire is then released for the stop bit, and the device's acknowledge is sampled on the following edge.

A send begins either from an upstream request carrying a byte or from a resend request raised by the companion receiver, which transmits a fixed resend code. Falling edges are filtered in two ways: edges that arrive too soon after the clock is released are ignored, and so are edges too close to the last accepted one. A refused acknowledge, a stalled clock or a lost bit position causes the whole byte to be sent again, up to a retry limit. An overall transfer watchdog bounds the total effort. On success the block pulses `done` and latches a free-running time stamp, which the receiver uses to discard stray edges that follow the transfer. On giving up it pulses `error`.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, both drive-low outputs are deasserted, so both bus wires are released.
- R2: An accepted request pulls the clock wire low for exactly INHIBIT_CYC cycles, during which data stays released. In the cycle the clock is released, the data wire is pulled low (start bit).
- R3: On successive accepted falling edges 1 to 8, the data wire carries request bits 0 to 7, least significant first (pulled low for a 0). Edge 9 carries the odd parity bit, which is 1 when the byte has an even number of ones. Edge 10 releases the data wire, giving a high stop bit.
- R4: Falling edges seen within MASK_CYC cycles of the clock release are ignored.
- R5: A falling edge fewer than GAP_MIN_CYC cycles after the last accepted edge is ignored.
- R6: If data is low at accepted edge 11, the transfer succeeds. `done` pulses for one cycle, `busy` falls in the same cycle, and `end_stamp` takes the value of the internal cycle stamp. The difference between two stamps therefore equals the cycles between the two `done` pulses.
- R7: If data is high at edge 11 (refused), the line is released and the same byte is sent again, starting with a fresh clock inhibit.
- R8: Once at least one bit has been sent, a wait of more than GAP_MAX_CYC cycles without an accepted edge releases the data wire and restarts the byte from the inhibit.
- R9: After RETRY_MAX restarts, the next fault pulses `error` for one cycle instead of retrying. The block then returns to idle without raising `done`.
- R10: If a transfer is still running XFER_TO_CYC cycles after acceptance, the block releases both wires, pulses `error` and returns to idle. This applies even when the device never clocks.
- R11: Requests are taken only while idle, and requests made while busy are ignored. `req_valid` takes priority over `resend_req`. A resend request transmits RESEND_CODE (default 0xFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Single-cycle request to send `req_byte` |
| req_byte | input | 8 | Byte to transmit |
| resend_req | input | 1 | Single-cycle request from the receiver to send the resend code |
| ps2_clk_i | input | 1 | Sensed level of the bus clock wire |
| ps2_data_i | input | 1 | Sensed level of the bus data wire |
| ps2_clk_drive_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_data_drive_low | output | 1 | 1 pulls the data wire low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on acknowledged transfer |
| error | output | 1 | One-cycle pulse when retries or the transfer watchdog are exhausted |
| end_stamp | output | STAMP_W | Cycle stamp captured at the last successful transfer |

## Verification
Bus inputs pass through SYNC_STAGES flops plus an edge register, so the data wire changes about SYNC_STAGES+1 cycles after the device's falling edge. The device model therefore samples each bit at its own rising edge, half a bus period later, well clear of that latency. The inhibit length is measured cycle by cycle at the falling system-clock edge. The drive-low levels are checked in the first cycle after release. `done` and `error` are registered one cycle after the qualifying edge, so counters are read only after a margin of several cycles once the device model finishes a frame. Time-stamp checks compare differences between two pulses rather than absolute values, which removes any dependence on when the stamp counter began.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_INHIBIT = 2'd1,
      TX_FRAME   = 2'd2
   } tx_state_e;

   // Bit positions of the outgoing frame, counted in accepted falling edges.
   localparam logic [3:0] POS_FIRST = 4'd1;
   localparam logic [3:0] POS_ACK   = 4'd11;

   function automatic logic odd_parity(input logic [7:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/ps2tx_sync_edge.sv
module ps2tx_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_line,
   input  logic data_line,
   output logic clk_fall,
   output logic data_s
);
   logic [STAGES-1:0] clk_sh;
   logic [STAGES-1:0] data_sh;
   logic              clk_prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ps2tx_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  clk_sh[0]  <= 1'b1;
                  data_sh[0] <= 1'b1;
               end else begin
                  clk_sh[0]  <= clk_line;
                  data_sh[0] <= data_line;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  clk_sh[i]  <= 1'b1;
                  data_sh[i] <= 1'b1;
               end else begin
                  clk_sh[i]  <= clk_sh[i-1];
                  data_sh[i] <= data_sh[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b1;
      else        clk_prev <= clk_sh[STAGES-1];
   end

   assign clk_fall = clk_prev & ~clk_sh[STAGES-1];
   assign data_s   = data_sh[STAGES-1];

endmodule

// File: rtl/ps2tx_gap_timer.sv
module ps2tx_gap_timer #(
   parameter int MASK_CYC    = 3000,
   parameter int GAP_MIN_CYC = 2000,
   parameter int GAP_MAX_CYC = 6000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic accept,
   output logic in_mask,
   output logic too_close,
   output logic too_long
);
   localparam int REL_W   = $clog2(MASK_CYC + 1);
   localparam int GAP_LIM = GAP_MAX_CYC + 1;
   localparam int GAP_W   = $clog2(GAP_LIM + 1);
   localparam logic [REL_W-1:0] REL_END = REL_W'(MASK_CYC);
   localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_LIM);
   localparam logic [GAP_W-1:0] GAP_LOW = GAP_W'(GAP_MIN_CYC);

   logic [REL_W-1:0] rel_cnt;
   logic [GAP_W-1:0] gap_cnt;

   generate
      if (GAP_MIN_CYC >= GAP_MAX_CYC) begin : g_bad_gap
         $error("ps2tx_gap_timer: GAP_MIN_CYC must be below GAP_MAX_CYC");
      end
      if (MASK_CYC < 1) begin : g_bad_mask
         $error("ps2tx_gap_timer: MASK_CYC must be positive");
      end
   endgenerate

   // Cycles since the clock wire was released, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rel_cnt <= REL_END;
      else if (start)            rel_cnt <= '0;
      else if (rel_cnt != REL_END) rel_cnt <= rel_cnt + 1'b1;
   end

   // Cycles since the last accepted edge, saturating one past the limit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gap_cnt <= GAP_END;
      else if (start)              gap_cnt <= GAP_END;
      else if (accept)             gap_cnt <= '0;
      else if (gap_cnt != GAP_END) gap_cnt <= gap_cnt + 1'b1;
   end

   assign in_mask   = rel_cnt < REL_END;
   assign too_close = gap_cnt < GAP_LOW;
   assign too_long  = gap_cnt == GAP_END;

   AST_ACCEPT_OUTSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !in_mask) else $error("edge taken inside release mask"); // R4
   AST_ACCEPT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !too_close) else $error("edge taken too close to previous"); // R5

endmodule

// File: rtl/ps2tx_bit_sel.sv
module ps2tx_bit_sel
   import ps2tx_pkg::*;
(
   input  logic [7:0] byte_i,
   input  logic [3:0] pos,
   output logic       drive_low,
   output logic       is_ack,
   output logic       bad_pos
);
   // Frame image indexed by edge position: start, data LSB first, parity,
   // then ones for every released position (stop and beyond).
   logic [15:0] image;

   assign image     = {6'h3F, odd_parity(byte_i), byte_i, 1'b0};
   assign drive_low = ~image[pos];
   assign is_ack    = pos == POS_ACK;
   assign bad_pos   = (pos < POS_FIRST) || (pos > POS_ACK);

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
   import ps2tx_pkg::*;
#(
   parameter int         INHIBIT_CYC = 10000,
   parameter int         MASK_CYC    = 3000,
   parameter int         GAP_MIN_CYC = 2000,
   parameter int         GAP_MAX_CYC = 6000,
   parameter int         RETRY_MAX   = 3,
   parameter int         XFER_TO_CYC = 1000000,
   parameter int         SYNC_STAGES = 2,
   parameter int         STAMP_W     = 32,
   parameter logic [7:0] RESEND_CODE = 8'hFE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [7:0]         req_byte,
   input  logic               resend_req,
   input  logic               ps2_clk_i,
   input  logic               ps2_data_i,
   output logic               ps2_clk_drive_low,
   output logic               ps2_data_drive_low,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic [STAMP_W-1:0] end_stamp
);
   localparam int HOLD_W  = $clog2(INHIBIT_CYC + 1);
   localparam int XFER_W  = $clog2(XFER_TO_CYC + 1);
   localparam int RETRY_W = $clog2(RETRY_MAX + 2);
   localparam logic [HOLD_W-1:0]  HOLD_LAST = HOLD_W'(INHIBIT_CYC - 1);
   localparam logic [XFER_W-1:0]  XFER_LAST = XFER_W'(XFER_TO_CYC - 1);
   localparam logic [RETRY_W-1:0] RETRY_LIM = RETRY_W'(RETRY_MAX);

   generate
      if (INHIBIT_CYC < 1) begin : g_bad_inh
         $error("ps2_host_tx: INHIBIT_CYC must be positive");
      end
      if (RETRY_MAX < 0) begin : g_bad_retry
         $error("ps2_host_tx: RETRY_MAX must not be negative");
      end
      if (XFER_TO_CYC <= INHIBIT_CYC) begin : g_bad_xfer
         $error("ps2_host_tx: XFER_TO_CYC must exceed INHIBIT_CYC");
      end
      if (STAMP_W < 1) begin : g_bad_stamp
         $error("ps2_host_tx: STAMP_W must be positive");
      end
   endgenerate

   tx_state_e          state;
   logic [7:0]         byte_q;
   logic [3:0]         pos_q;
   logic [HOLD_W-1:0]  hold_cnt;
   logic [XFER_W-1:0]  xfer_cnt;
   logic [RETRY_W-1:0] retry_cnt;
   logic               clk_oe_q, data_oe_q, done_q, error_q;
   logic [STAMP_W-1:0] stamp_q, end_stamp_q;

   logic clk_fall, data_s;
   logic in_mask, too_close, too_long;
   logic drive_low, is_ack, bad_pos;
   logic xfer_expire, rel_go, gap_fault, edge_take, frame_fault;

   ps2tx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_line  (ps2_clk_i),
      .data_line (ps2_data_i),
      .clk_fall  (clk_fall),
      .data_s    (data_s)
   );

   ps2tx_gap_timer #(
      .MASK_CYC    (MASK_CYC),
      .GAP_MIN_CYC (GAP_MIN_CYC),
      .GAP_MAX_CYC (GAP_MAX_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rel_go),
      .accept    (edge_take),
      .in_mask   (in_mask),
      .too_close (too_close),
      .too_long  (too_long)
   );

   ps2tx_bit_sel u_bits (
      .byte_i    (byte_q),
      .pos       (pos_q),
      .drive_low (drive_low),
      .is_ack    (is_ack),
      .bad_pos   (bad_pos)
   );

   assign xfer_expire = (state != TX_IDLE) && (xfer_cnt == XFER_LAST);
   assign rel_go      = (state == TX_INHIBIT) && (hold_cnt == HOLD_LAST) && !xfer_expire;
   assign gap_fault   = (state == TX_FRAME) && (pos_q > POS_FIRST) && too_long && !xfer_expire;
   assign edge_take   = (state == TX_FRAME) && clk_fall && !in_mask && !too_close
                        && !xfer_expire && !gap_fault;
   assign frame_fault = gap_fault || (edge_take && (bad_pos || (is_ack && data_s)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= TX_IDLE;
         byte_q      <= '0;
         pos_q       <= POS_FIRST;
         hold_cnt    <= '0;
         xfer_cnt    <= '0;
         retry_cnt   <= '0;
         clk_oe_q    <= 1'b0;
         data_oe_q   <= 1'b0;
         done_q      <= 1'b0;
         error_q     <= 1'b0;
         stamp_q     <= '0;
         end_stamp_q <= '0;
      end else begin
         done_q  <= 1'b0;
         error_q <= 1'b0;
         stamp_q <= stamp_q + 1'b1;
         unique case (state)
            TX_IDLE: begin
               if (req_valid || resend_req) begin
                  byte_q    <= req_valid ? req_byte : RESEND_CODE;
                  state     <= TX_INHIBIT;
                  clk_oe_q  <= 1'b1;
                  data_oe_q <= 1'b0;
                  hold_cnt  <= '0;
                  xfer_cnt  <= '0;
                  retry_cnt <= '0;
               end
            end
            TX_INHIBIT, TX_FRAME: begin
               xfer_cnt <= xfer_cnt + 1'b1;
               if (xfer_expire) begin
                  clk_oe_q  <= 1'b0;
                  data_oe_q <= 1'b0;
                  error_q   <= 1'b1;
                  state     <= TX_IDLE;
               end else if (state == TX_INHIBIT) begin
                  if (rel_go) begin
                     clk_oe_q  <= 1'b0;
                     data_oe_q <= 1'b1;
                     pos_q     <= POS_FIRST;
                     state     <= TX_FRAME;
                  end else begin
                     hold_cnt <= hold_cnt + 1'b1;
                  end
               end else if (frame_fault) begin
                  data_oe_q <= 1'b0;
                  if (retry_cnt == RETRY_LIM) begin
                     error_q <= 1'b1;
                     state   <= TX_IDLE;
                  end else begin
                     retry_cnt <= retry_cnt + 1'b1;
                     clk_oe_q  <= 1'b1;
                     hold_cnt  <= '0;
                     state     <= TX_INHIBIT;
                  end
               end else if (edge_take) begin
                  if (is_ack) begin
                     done_q      <= 1'b1;
                     end_stamp_q <= stamp_q;
                     state       <= TX_IDLE;
                  end else begin
                     data_oe_q <= drive_low;
                     pos_q     <= pos_q + 1'b1;
                  end
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign ps2_clk_drive_low  = clk_oe_q;
   assign ps2_data_drive_low = data_oe_q;
   assign busy               = state != TX_IDLE;
   assign done               = done_q;
   assign error              = error_q;
   assign end_stamp          = end_stamp_q;

   AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ps2_clk_drive_low && !ps2_data_drive_low)) else $error("idle drives bus"); // R1
   AST_INHIBIT_DATA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      ps2_clk_drive_low |-> !ps2_data_drive_low) else $error("data driven during inhibit"); // R2
   AST_RELEASE_START: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ps2_clk_drive_low) && busy) |-> ps2_data_drive_low) else $error("no start bit"); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !error)) else $error("done while busy"); // R6
   AST_ERROR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !busy) else $error("error while busy"); // R9
   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      retry_cnt <= RETRY_LIM) else $error("retry count past limit"); // R9
   AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (req_valid || resend_req)) |=> $stable(byte_q)) else $error("byte changed while busy"); // R11

endmodule

// File: tb/ps2_host_tx_test.sv
`timescale 1ns/1ps
module ps2_host_tx_test;
   localparam int INH    = 40;
   localparam int MASK   = 30;
   localparam int GMIN   = 20;
   localparam int GMAX   = 60;
   localparam int RETRY  = 2;
   localparam int XTO    = 3000;
   localparam int HALF   = 20;
   localparam int STARTW = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [7:0] req_byte = '0;
   logic resend_req = 1'b0;
   logic dev_clk_low = 1'b0;
   logic dev_data_low = 1'b0;
   logic clk_drv, data_drv, busy, done, error;
   logic [31:0] end_stamp;
   logic line_clk, line_data;

   int checks = 0, errs = 0;
   int done_n = 0, err_n = 0, inh_n = 0, run = 0, last_inh = 0;
   logic start_ok = 1'b0;
   int cyc = 0, cyc_a = 0, cyc_b = 0;
   logic [31:0] st_a = '0, st_b = '0;

   always #2.5 clk = ~clk;

   assign line_clk  = ~(clk_drv | dev_clk_low);
   assign line_data = ~(data_drv | dev_data_low);

   ps2_host_tx #(
      .INHIBIT_CYC(INH), .MASK_CYC(MASK), .GAP_MIN_CYC(GMIN), .GAP_MAX_CYC(GMAX),
      .RETRY_MAX(RETRY), .XFER_TO_CYC(XTO), .SYNC_STAGES(2), .STAMP_W(32),
      .RESEND_CODE(8'hFE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
      .resend_req(resend_req), .ps2_clk_i(line_clk), .ps2_data_i(line_data),
      .ps2_clk_drive_low(clk_drv), .ps2_data_drive_low(data_drv),
      .busy(busy), .done(done), .error(error), .end_stamp(end_stamp)
   );

   // Passive monitor, sampled away from the active edge.
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (clk_drv) run++;
         else if (run > 0) begin
            last_inh = run;
            start_ok = data_drv;
            inh_n++;
            run = 0;
         end
         if (done) begin
            done_n++;
            cyc_a = cyc_b; st_a = st_b;
            cyc_b = cyc;   st_b = end_stamp;
         end
         if (error) err_n++;
      end
   end

   function automatic logic exp_parity(input logic [7:0] b);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(b[i]);
      return (ones % 2) == 0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input bit as_resend);
      @(negedge clk);
      if (as_resend) resend_req = 1'b1;
      else begin req_valid = 1'b1; req_byte = b; end
      @(negedge clk);
      req_valid = 1'b0; resend_req = 1'b0;
   endtask

   // Device model: waits for inhibit and release, then clocks one frame.
   task automatic dev_serve(input bit nack, input int stall_after, input bit glitch_rel,
                            input bit glitch_gap, output logic [7:0] got,
                            output logic par, output logic stp);
      got = '0; par = 1'b0; stp = 1'b0;
      do @(negedge clk); while (!clk_drv);
      do @(negedge clk); while (!(!clk_drv && data_drv));
      if (glitch_rel) begin
         repeat (5) @(negedge clk);
         dev_clk_low = 1'b1;
         repeat (2) @(negedge clk);
         dev_clk_low = 1'b0;
         repeat (STARTW - 7) @(negedge clk);
      end else begin
         repeat (STARTW) @(negedge clk);
      end
      for (int k = 1; k <= 11; k++) begin
         if (stall_after > 0 && k > stall_after) return;
         dev_clk_low = 1'b1;
         if (glitch_gap && k == 4) begin
            repeat (4) @(negedge clk);
            dev_clk_low = 1'b0;
            repeat (2) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (HALF - 6) @(negedge clk);
         end else begin
            repeat (HALF) @(negedge clk);
         end
         dev_clk_low = 1'b0;
         if (k <= 8) got[k-1] = line_data;
         else if (k == 9) par = line_data;
         else if (k == 10) stp = line_data;
         if (k == 10 && !nack) dev_data_low = 1'b1;
         if (k == 11) begin
            dev_data_low = 1'b0;
            return;
         end
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic good_xfer(input logic [7:0] b, input bit gr, input bit gg, input string tag);
      logic [7:0] got; logic par, stp;
      int d0 = done_n, e0 = err_n;
      send(b, 1'b0);
      dev_serve(1'b0, 0, gr, gg, got, par, stp);
      repeat (8) @(negedge clk);
      chk(got == b, {tag, " R3 data bits"}, got, b);
      chk(par == exp_parity(b), {tag, " R3 parity"}, par, exp_parity(b));
      chk(stp == 1'b1, {tag, " R3 stop"}, stp, 1);
      chk(last_inh == INH, {tag, " R2 inhibit length"}, last_inh, INH);
      chk(start_ok == 1'b1, {tag, " R2 start bit"}, start_ok, 1);
      chk(done_n == d0 + 1, {tag, " R6 done"}, done_n, d0 + 1);
      chk(err_n == e0 && !busy, {tag, " R6 idle after done"}, err_n, e0);
   endtask

   initial begin
      logic [7:0] got; logic par, stp;
      int d0, e0, i0;
      void'($urandom(32'h5EED));
      repeat (4) @(negedge clk);
      chk(!clk_drv && !data_drv && !busy && !done && !error, "R1 reset state",
          {clk_drv, data_drv, busy, done, error}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!clk_drv && !data_drv && !busy, "R1 idle after reset", {clk_drv, data_drv, busy}, 0);

      good_xfer(8'h00, 1'b0, 1'b0, "zero");
      good_xfer(8'hFF, 1'b0, 1'b0, "ones");
      chk(32'(st_b - st_a) == 32'(cyc_b - cyc_a), "R6 end stamp spacing",
          st_b - st_a, cyc_b - cyc_a);
      for (int n = 0; n < 5; n++) good_xfer(8'($urandom), 1'b0, 1'b0, "random");

      good_xfer(8'hA5, 1'b1, 1'b0, "R4 masked glitch");
      good_xfer(8'h3C, 1'b0, 1'b1, "R5 close glitch");

      // R7: refused once, then acknowledged
      d0 = done_n; e0 = err_n; i0 = inh_n;
      send(8'h5A, 1'b0);
      dev_serve(1'b1, 0, 1'b0, 1'b0, got, par, stp);
      dev_serve(1'b0, 0, 1'b0, 1'b0, got, par, stp);
      repeat (8) @(negedge clk);
      chk(got == 8'h5A, "R7 resent byte", got, 8'h5A);
      chk(done_n == d0 + 1 && err_n == e0, "R7 done after retry", done_n, d0 + 1);
      chk(inh_n == i0 + 2, "R7 fresh inhibit", inh_n, i0 + 2);

      // R8: device stalls after three edges
      d0 = done_n; i0 = inh_n;
      send(8'h81, 1'b0);
      dev_serve(1'b0, 3, 1'b0, 1'b0, got, par, stp);
      dev_serve(1'b0, 0, 1'b0, 1'b0, got, par, stp);
      repeat (8) @(negedge clk);
      chk(got == 8'h81 && done_n == d0 + 1, "R8 retry after stall", got, 8'h81);
      chk(inh_n == i0 + 2, "R8 restart inhibit", inh_n, i0 + 2);

      // R9: refused on every attempt
      d0 = done_n; e0 = err_n;
      send(8'h42, 1'b0);
      for (int a = 0; a <= RETRY; a++) dev_serve(1'b1, 0, 1'b0, 1'b0, got, par, stp);
      repeat (8) @(negedge clk);
      chk(err_n == e0 + 1, "R9 error after limit", err_n, e0 + 1);
      chk(done_n == d0 && !busy, "R9 no done, idle", done_n, d0);

      // R10: device never clocks
      e0 = err_n;
      send(8'h17, 1'b0);
      repeat (XTO + 100) @(negedge clk);
      chk(err_n == e0 + 1, "R10 transfer watchdog", err_n, e0 + 1);
      chk(!busy && !clk_drv && !data_drv, "R10 lines released", {busy, clk_drv, data_drv}, 0);

      // R11: resend code, priority, ignore while busy
      send(8'h00, 1'b1);
      dev_serve(1'b0, 0, 1'b0, 1'b0, got, par, stp);
      repeat (8) @(negedge clk);
      chk(got == 8'hFE, "R11 resend code", got, 8'hFE);
      @(negedge clk);
      req_valid = 1'b1; req_byte = 8'h6B; resend_req = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; resend_req = 1'b0;
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_byte = 8'h99;
      @(negedge clk);
      req_valid = 1'b0;
      d0 = done_n;
      dev_serve(1'b0, 0, 1'b0, 1'b0, got, par, stp);
      repeat (60) @(negedge clk);
      chk(got == 8'h6B, "R11 priority and busy ignore", got, 8'h6B);
      chk(done_n == d0 + 1 && !busy && !clk_drv, "R11 single transfer", done_n, d0 + 1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule